// File: doc/BRIEF.md
# Parallel EEPROM Page Write Load Controller

This block is the device side of an asynchronous parallel EEPROM write port, re-timed onto a system clock. The active-low chip enable, write enable and output enable strobes are synchronised. Each qualifying write strobe deposits one byte into a page buffer. The address is taken when the combined write condition begins. The data is taken when that condition ends.

The host can issue several byte loads back to back. Each rising edge of write enable re-arms an inactivity timer, and each falling edge of write enable halts it. When the timer runs out, a self-timed program cycle copies into the storage array only the buffer slots that were loaded. The busy output is high for the whole program cycle. After reset, a start-up window blocks all writes.

A plain read path returns the stored byte when chip enable and output enable are low and write enable is high. It exists so that the array contents can be seen at the ports. All timer lengths are parameters counted in clock cycles. The array holds 2^ADDR_W bytes, and a full 8K x 8 device uses ADDR_W = 13.

Top module: `eeprom_page_loader`

## Requirements
- R1: While reset is asserted and right after it, `busy` is 0 and `dout` is 0.
- R2: For INIT_CYCLES clocks after reset, a byte load is discarded and no program cycle follows it.
- R3: A write strobe controlled by write enable stores the data. Chip enable is low first, write enable then pulses low, and output enable is high. The stored byte can later be read at that address.
- R4: A write strobe controlled by chip enable also stores its data. Write enable is low first and chip enable then pulses low.
- R5: Address bits [PAGE_W-1:0] select the slot in the page buffer, and slots may be loaded in any order. All bytes of one program cycle land in the page given by bits [ADDR_W-1:PAGE_W] of the final load.
- R6: A program cycle writes only the slots loaded since the previous cycle. Other bytes of the same page keep their contents.
- R7: A new falling edge of write enable cancels the running timer, and the next rising edge restarts it. Loads spaced less than BLC_CYCLES apart therefore form one page with no busy in between. Programming starts only after BLC_CYCLES of write enable high following the last load.
- R8: A write strobe that lasts fewer than MIN_PULSE_CYCLES sampled clocks is discarded.
- R9: Byte loads made while `busy` is high are discarded and do not start a later program cycle.
- R10: The record of loaded slots is empty once a program cycle ends. Slots loaded for an earlier page are not written again with a later page.
- R11: A strobe made with output enable low loads nothing.
- R12: `busy` stays high for exactly WC_CYCLES clocks for each program cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte address for loads and reads |
| din | input | DATA_W | Write data |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| busy | output | 1 | High while the program cycle runs |
| dout | output | DATA_W | Stored byte during a read, otherwise 0 |

## Verification
The bench builds the block with ADDR_W = 8, giving eight pages of 32 bytes. It sets BLC_CYCLES = 40, WC_CYCLES = 60, INIT_CYCLES = 40 and MIN_PULSE_CYCLES = 3. With these short timers, the bench can load a byte inside the start-up window and space loads just under the inactivity limit. It can also check the exact busy length and land a load in the middle of a program cycle, all within a few thousand clocks. The small array lets cross-page effects be checked in neighbouring pages.

// File: rtl/epl_pkg.sv
package epl_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PROG = 1'b1
    } prog_state_e;
endpackage

// File: rtl/epl_strobe_front.sv
// Synchronises the three strobes and turns them into one-cycle events.
module epl_strobe_front #(
    parameter int MIN_PULSE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_start,
    output logic wr_end_ok,
    output logic we_rise,
    output logic we_fall,
    output logic rd_en
);
    localparam int PC_W = $clog2(MIN_PULSE_CYCLES + 1);
    localparam logic [PC_W-1:0] PC_MAX = PC_W'(MIN_PULSE_CYCLES);

    typedef struct packed {
        logic [2:0]      s1;       // {ce, we, oe} first stage
        logic [2:0]      s2;       // second stage
        logic            act_prev;
        logic            we_prev;
        logic [PC_W-1:0] pcnt;
    } front_t;

    front_t q, d;
    logic ce_s, we_s, oe_s, act;

    always_comb begin
        ce_s = q.s2[2];
        we_s = q.s2[1];
        oe_s = q.s2[0];
        act  = !ce_s && !we_s && oe_s;

        d          = q;
        d.s1       = {ce_n, we_n, oe_n};
        d.s2       = q.s1;
        d.act_prev = act;
        d.we_prev  = we_s;
        if (act) begin
            d.pcnt = (q.pcnt == PC_MAX) ? q.pcnt : q.pcnt + PC_W'(1);
        end else begin
            d.pcnt = '0;
        end

        wr_start  = act && !q.act_prev;
        wr_end_ok = !act && q.act_prev && (q.pcnt >= PC_MAX);
        we_rise   = we_s && !q.we_prev;
        we_fall   = !we_s && q.we_prev;
        rd_en     = !ce_s && !oe_s && we_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.s1       <= 3'b111;
            q.s2       <= 3'b111;
            q.act_prev <= 1'b0;
            q.we_prev  <= 1'b1;
            q.pcnt     <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/epl_page_ctrl.sv
// Page buffer, loaded-slot mask, inactivity timer and program sequencer.
module epl_page_ctrl
    import epl_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 5,
    parameter int BLC_CYCLES  = 5000,
    parameter int WC_CYCLES   = 250000,
    parameter int INIT_CYCLES = 250000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     din,
    input  logic                  wr_start,
    input  logic                  wr_end_ok,
    input  logic                  we_rise,
    input  logic                  we_fall,
    output logic                  busy,
    output logic                  init_done,
    output logic [(1<<PAGE_W)-1:0] pend_mask,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_waddr,
    output logic [DATA_W-1:0]     mem_wdata
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int PG_W       = ADDR_W - PAGE_W;
    localparam int INIT_W     = $clog2(INIT_CYCLES + 1);
    localparam int BLC_W      = $clog2(BLC_CYCLES + 1);
    localparam int WC_W       = $clog2(WC_CYCLES + 1);

    typedef struct packed {
        prog_state_e                        st;
        logic [INIT_W-1:0]                  icnt;
        logic [ADDR_W-1:0]                  alat;
        logic [PG_W-1:0]                    page;
        logic [PAGE_BYTES-1:0][DATA_W-1:0]  pbuf;
        logic [PAGE_BYTES-1:0]              mask;
        logic                               t_on;
        logic [BLC_W-1:0]                   tcnt;
        logic [WC_W-1:0]                    wcnt;
        logic [PAGE_W:0]                    slot;
    } ctrl_t;

    ctrl_t q, d;
    logic  can_load;

    always_comb begin
        d        = q;
        mem_we   = 1'b0;
        can_load = (q.icnt == '0) && (q.st == ST_IDLE);

        if (q.icnt != '0) begin
            d.icnt = q.icnt - INIT_W'(1);
        end
        // address is taken when the write condition begins
        if (wr_start) begin
            d.alat = addr;
        end

        case (q.st)
            ST_IDLE: begin
                // data is taken when the write condition ends
                if (wr_end_ok && can_load) begin
                    d.pbuf[q.alat[PAGE_W-1:0]] = din;
                    d.mask[q.alat[PAGE_W-1:0]] = 1'b1;
                    d.page = q.alat[ADDR_W-1:PAGE_W];
                end
                if (we_rise && (d.mask != '0)) begin
                    d.t_on = 1'b1;
                    d.tcnt = BLC_W'(BLC_CYCLES);
                end else if (we_fall) begin
                    d.t_on = 1'b0;
                end else if (q.t_on) begin
                    if (q.tcnt <= BLC_W'(1)) begin
                        d.t_on = 1'b0;
                        d.st   = ST_PROG;
                        d.wcnt = WC_W'(WC_CYCLES);
                        d.slot = '0;
                    end else begin
                        d.tcnt = q.tcnt - BLC_W'(1);
                    end
                end
            end
            ST_PROG: begin
                if (!q.slot[PAGE_W]) begin
                    mem_we = q.mask[q.slot[PAGE_W-1:0]];
                    d.slot = q.slot + (PAGE_W+1)'(1);
                end
                if (q.wcnt <= WC_W'(1)) begin
                    d.st   = ST_IDLE;
                    d.mask = '0;
                end else begin
                    d.wcnt = q.wcnt - WC_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase

        mem_waddr = {q.page, q.slot[PAGE_W-1:0]};
        mem_wdata = q.pbuf[q.slot[PAGE_W-1:0]];
        busy      = (q.st == ST_PROG);
        init_done = (q.icnt == '0);
        pend_mask = q.mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.icnt <= INIT_W'(INIT_CYCLES);
            q.alat <= '0;
            q.page <= '0;
            q.pbuf <= '0;
            q.mask <= '0;
            q.t_on <= 1'b0;
            q.tcnt <= '0;
            q.wcnt <= '0;
            q.slot <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/epl_store_array.sv
// Byte storage with one write port and one registered read port.
module epl_store_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        rdata <= cells[raddr];
    end
endmodule

// File: rtl/eeprom_page_loader.sv
module eeprom_page_loader #(
    parameter int ADDR_W           = 11,
    parameter int DATA_W           = 8,
    parameter int PAGE_W           = 5,
    parameter int BLC_CYCLES       = 5000,
    parameter int WC_CYCLES        = 250000,
    parameter int INIT_CYCLES      = 250000,
    parameter int MIN_PULSE_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    output logic              busy,
    output logic [DATA_W-1:0] dout
);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic                  wr_start, wr_end_ok, we_rise, we_fall, rd_en;
    logic                  init_done;
    logic [PAGE_BYTES-1:0] pend_mask;
    logic                  mem_we;
    logic [ADDR_W-1:0]     mem_waddr;
    logic [DATA_W-1:0]     mem_wdata;
    logic [DATA_W-1:0]     rd_data;

    epl_strobe_front #(
        .MIN_PULSE_CYCLES(MIN_PULSE_CYCLES)
    ) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .wr_start (wr_start),
        .wr_end_ok(wr_end_ok),
        .we_rise  (we_rise),
        .we_fall  (we_fall),
        .rd_en    (rd_en)
    );

    epl_page_ctrl #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .PAGE_W     (PAGE_W),
        .BLC_CYCLES (BLC_CYCLES),
        .WC_CYCLES  (WC_CYCLES),
        .INIT_CYCLES(INIT_CYCLES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .din      (din),
        .wr_start (wr_start),
        .wr_end_ok(wr_end_ok),
        .we_rise  (we_rise),
        .we_fall  (we_fall),
        .busy     (busy),
        .init_done(init_done),
        .pend_mask(pend_mask),
        .mem_we   (mem_we),
        .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata)
    );

    epl_store_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_array (
        .clk  (clk),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(mem_wdata),
        .raddr(addr),
        .rdata(rd_data)
    );

    assign dout = rd_en ? rd_data : '0;
endmodule

// File: rtl/epl_checker.sv
module epl_checker #(
    parameter int WC_CYCLES  = 250000,
    parameter int PAGE_BYTES = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  busy,
    input logic                  init_done,
    input logic                  mem_we,
    input logic [PAGE_BYTES-1:0] pend_mask
);
    // busy run length, counted here so no deep $past is needed
    int blen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) blen <= 0;
        else        blen <= busy ? blen + 1 : 0;
    end

    a_r12_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (blen == WC_CYCLES));

    a_r9_store_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    a_r2_quiet_in_init: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> (!busy && !mem_we));

    a_r10_mask_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (pend_mask == '0));
endmodule

bind eeprom_page_loader epl_checker #(
    .WC_CYCLES (WC_CYCLES),
    .PAGE_BYTES(1 << PAGE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .init_done(init_done),
    .mem_we   (mem_we),
    .pend_mask(pend_mask)
);

// File: tb/eeprom_page_loader_bench.sv
`timescale 1ns/1ps
module eeprom_page_loader_bench;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int BLC    = 40;
    localparam int WC     = 60;
    localparam int INIT   = 40;
    localparam int MINP   = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] din = '0;
    logic              ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic              busy;
    logic [DATA_W-1:0] dout;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] a;
        logic [7:0] d;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    eeprom_page_loader #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(5),
        .BLC_CYCLES(BLC), .WC_CYCLES(WC), .INIT_CYCLES(INIT),
        .MIN_PULSE_CYCLES(MINP)
    ) u_eeprom_page_loader (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .busy(busy), .dout(dout)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // write enable pulses inside a chip enable window
    task automatic load_we(input logic [7:0] a, input logic [7:0] d, input int len, input logic oe);
        @(negedge clk);
        addr = a; din = d; oe_n = oe; ce_n = 1'b0;
        tick(1);
        we_n = 1'b0;
        tick(len);
        we_n = 1'b1;
        tick(2);
        ce_n = 1'b1; oe_n = 1'b1;
        tick(1);
    endtask

    // chip enable pulses inside a write enable window
    task automatic load_ce(input logic [7:0] a, input logic [7:0] d, input int len);
        @(negedge clk);
        addr = a; din = d; oe_n = 1'b1; we_n = 1'b0;
        tick(1);
        ce_n = 1'b0;
        tick(len);
        ce_n = 1'b1;
        tick(2);
        we_n = 1'b1;
        tick(1);
    endtask

    task automatic read_byte(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        tick(5);
        v = dout;
        ce_n = 1'b1; oe_n = 1'b1;
        tick(3);
    endtask

    task automatic expect_byte(input logic [7:0] a, input logic [7:0] d, input string req);
        exp_t e;
        e.a = a; e.d = d; e.req = req;
        sb.push_back(e);
    endtask

    // monitor side of the scoreboard: read each expected byte and compare
    task automatic drain();
        while (sb.size() > 0) begin
            exp_t e;
            logic [7:0] v;
            e = sb.pop_front();
            read_byte(e.a, v);
            chk(v === e.d, e.req, int'(v), int'(e.d));
        end
    endtask

    task automatic wait_prog(input string req);
        int w = 0;
        int len = 0;
        while (!busy && w < BLC + 40) begin tick(1); w++; end
        chk(busy === 1'b1, req, int'(busy), 1);
        while (busy && len < WC + 20) begin tick(1); len++; end
        chk(len == WC, "R12 busy length", len, WC);
    endtask

    task automatic quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if (busy !== 1'b0) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    initial begin
        tick(3);
        chk(busy === 1'b0, "R1 busy in reset", int'(busy), 0);
        chk(dout === '0, "R1 dout in reset", int'(dout), 0);
        rst_n = 1'b1;
        tick(1);
        chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);

        // R2: load inside start-up window is discarded
        load_we(8'h10, 8'h5A, 4, 1'b1);
        quiet(BLC + 30, "R2 no program after load in start-up window");

        // R3: write-enable-controlled byte
        load_we(8'h10, 8'hA5, 4, 1'b1);
        wait_prog("R3 program starts");
        expect_byte(8'h10, 8'hA5, "R3 byte stored");
        // R4: chip-enable-controlled byte
        load_ce(8'h21, 8'h3C, 4);
        wait_prog("R4 program starts");
        expect_byte(8'h21, 8'h3C, "R4 byte stored");
        drain();

        // known contents for page 2 and page 3
        load_we(8'h44, 8'h44, 4, 1'b1);
        load_we(8'h43, 8'h11, 4, 1'b1);
        wait_prog("R5 preload page 2");
        load_we(8'h69, 8'hE9, 4, 1'b1);
        load_we(8'h63, 8'hEE, 4, 1'b1);
        load_we(8'h67, 8'hEF, 4, 1'b1);
        wait_prog("R5 preload page 3");

        // R5 / R7: out-of-order loads, spaced below the timer limit
        load_we(8'h29, 8'h99, 4, 1'b1);
        quiet(BLC - 10, "R7 no busy between spaced loads");
        load_we(8'h27, 8'h77, 4, 1'b1);
        quiet(BLC - 10, "R7 no busy between spaced loads");
        load_we(8'h43, 8'h33, 4, 1'b1);
        quiet(BLC - 8, "R7 no busy before timer expiry");
        tick(12);
        chk(busy === 1'b1, "R7 busy after timer expiry", int'(busy), 1);
        while (busy) tick(1);
        expect_byte(8'h49, 8'h99, "R5 page from last load");
        expect_byte(8'h47, 8'h77, "R5 page from last load");
        expect_byte(8'h43, 8'h33, "R5 slot from low bits");
        expect_byte(8'h44, 8'h44, "R6 unloaded byte kept");
        drain();

        // R10: a fresh single load must not replay old slots
        load_we(8'h60, 8'hC0, 4, 1'b1);
        wait_prog("R10 program starts");
        expect_byte(8'h60, 8'hC0, "R10 new byte stored");
        expect_byte(8'h63, 8'hEE, "R10 old slot not replayed");
        expect_byte(8'h67, 8'hEF, "R10 old slot not replayed");
        expect_byte(8'h69, 8'hE9, "R10 old slot not replayed");
        drain();

        // R8: short strobe
        load_we(8'h60, 8'h01, 1, 1'b1);
        quiet(BLC + 20, "R8 short strobe starts nothing");
        expect_byte(8'h60, 8'hC0, "R8 byte unchanged");
        // R11: output enable low
        load_we(8'h60, 8'h02, 4, 1'b0);
        quiet(BLC + 20, "R11 strobe with output enable low starts nothing");
        expect_byte(8'h60, 8'hC0, "R11 byte unchanged");
        drain();

        // R9: load during a program cycle
        load_we(8'h70, 8'h70, 4, 1'b1);
        while (!busy) tick(1);
        load_we(8'h60, 8'h55, 4, 1'b1);
        chk(busy === 1'b1, "R9 load finished inside program cycle", int'(busy), 1);
        while (busy) tick(1);
        quiet(BLC + 20, "R9 ignored load starts no later program");
        expect_byte(8'h70, 8'h70, "R9 pending byte stored");
        expect_byte(8'h60, 8'hC0, "R9 byte unchanged");
        drain();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule